// File: doc/BRIEF.md
# Two-Stage Key-Locked Watchdog Timer

This block is a watchdog with two timeout stages that run in sequence. A programmable divider turns the system clock into a slow tick. Stage 0 counts ticks up to its own limit. When it expires, it fires its chosen action and hands over to stage 1, which counts to a separate limit and then fires its own action. Each stage picks one of four actions: none, interrupt, CPU reset or system reset. The two reset outputs are pulses whose widths are programmable.

Software reaches the block over a small register bus (address, write data, write strobe, combinational read data). Every register except the key register is guarded. A write to a guarded register lands only while the key register holds the 32-bit unlock value. Writing any other value to the key register locks the block again. Software restarts the sequence by writing the feed register. A level interrupt stays asserted until software writes the interrupt-clear register.

Top module: `kswd`

## Requirements
- R1: The key register sits at address 5 and reads back 1 in bit 0 while unlocked. Writing 0x50D83AA1 to it unlocks the block, and writing any other value locks it. While locked, writes to control (0), divider (1), stage timeouts (2, 3), feed (4) and interrupt clear (6) have no effect. All registers reset to 0 and the block resets locked.
- R2: The control register (address 0) holds: bit 0 enable, bit 1 level-interrupt mode, bits 3:2 stage-0 action, bits 5:4 stage-1 action, bits 8:6 CPU pulse code, bits 11:9 system pulse code. Action codes are 0 none, 1 interrupt, 2 CPU reset, 3 system reset. A stage fires only the output its code selects.
- R3: Stage 0 expires on the T0-th tick after enable or feed, where T0 is the value at address 2. Stage 1 then starts from zero and expires on its T1-th tick, where T1 is the value at address 3. A timeout of 0 acts as 1.
- R4: With divider value N (address 1), a tick occurs every N clock cycles, counted from the edge that enables the block. A value of 0 acts as 1.
- R5: A write to the feed register returns the block to stage 0 with the tick count and the divider phase cleared.
- R6: While enable is 0, nothing counts. All three outputs are low from the cycle after the edge that clears enable, and any pulse in progress is cut short.
- R7: A reset output stays high for exactly (code+1)*32 clock cycles after the edge at which its stage expires.
- R8: In level mode, the interrupt goes high after an interrupt-action expiry and stays high. In pulse mode, it is high for exactly one cycle.
- R9: A stage with action 0 still expires on time and hands over to the next stage, but drives no output.
- R10: Once stage 1 has expired, the block stays there with no further action until it is fed or disabled.
- R11: A write to the interrupt-clear register drops a level interrupt at the next edge. A feed write leaves it asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Watchdog interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest situation to reach from the ports is a write that must be shown to be ignored after the block has locked itself again while running. The stimulus starts the watchdog, writes a wrong key and then tries to feed it. The bench then measures the interrupt's arrival against the original enable edge. A shifted arrival would show that the feed slipped through. Other stimulus measures the expiry times, pulse widths and no-wrap behaviour with a divider of 0 and a timeout of 0. A cycle-by-cycle behavioural model is compared with every output on every clock.

// File: rtl/kswd_pkg.sv
package kswd_pkg;

    localparam int ADDR_W    = 3;
    localparam int STAGES    = 2;
    localparam int SIDX_W    = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam int LEN_W     = 3;
    localparam int RST_KINDS = 2;
    localparam int RST_CPU   = 0;
    localparam int RST_SYS   = 1;

    localparam logic [31:0] UNLOCK_KEY = 32'h50D8_3AA1;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TMO0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_FEED = 3'd4;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd5;
    localparam logic [ADDR_W-1:0] A_ICLR = 3'd6;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_IRQ  = 2'd1,
        ACT_CPU  = 2'd2,
        ACT_SYS  = 2'd3
    } act_e;

    typedef struct packed {
        logic [LEN_W-1:0]          sys_len;
        logic [LEN_W-1:0]          cpu_len;
        logic [STAGES-1:0][1:0]    act;
        logic                      irq_level;
        logic                      enable;
    } ctrl_t;

    function automatic int pulse_cycles(input int code, input int unit);
        return (code + 1) * unit;
    endfunction

endpackage

// File: rtl/kswd_regs.sv
module kswd_regs
    import kswd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int TMO_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          we,
    output ctrl_t                         ctrl,
    output logic [DIV_W-1:0]              div,
    output logic [STAGES-1:0][TMO_W-1:0]  tmo,
    output logic                          feed_p,
    output logic                          iclr_p,
    output logic [DATA_W-1:0]             rdata
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic unlocked;
    logic wr_ok;

    assign wr_ok  = we && unlocked;
    assign feed_p = wr_ok && (addr == A_FEED);
    assign iclr_p = wr_ok && (addr == A_ICLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (we && addr == A_KEY) begin
            unlocked <= (wdata == DATA_W'(UNLOCK_KEY));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            div  <= '0;
            tmo  <= '0;
        end else if (wr_ok) begin
            if (addr == A_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (addr == A_DIV)  div  <= wdata[DIV_W-1:0];
            for (int s = 0; s < STAGES; s++) begin
                if (addr == ADDR_W'(int'(A_TMO0) + s)) tmo[s] <= wdata[TMO_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) rdata[CTRL_W-1:0] = ctrl;
        if (addr == A_DIV)  rdata[DIV_W-1:0]  = div;
        for (int s = 0; s < STAGES; s++) begin
            if (addr == ADDR_W'(int'(A_TMO0) + s)) rdata[TMO_W-1:0] = tmo[s];
        end
        if (addr == A_KEY)  rdata[0] = unlocked;
    end

    // R1: a locked control write leaves the control register untouched
    assert_locked_ctrl_R1: assert property (@(posedge clk) disable iff (rst)
        (we && !unlocked && addr == A_CTRL) |=> $stable(ctrl));

    // R1: a wrong key always leaves the block locked
    assert_relock_R1: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_KEY && wdata != DATA_W'(UNLOCK_KEY)) |=> !unlocked);

endmodule

// File: rtl/kswd_tick.sv
module kswd_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre;
    logic [DIV_W-1:0] div_m1;

    assign div_m1 = (div == '0) ? '0 : div - 1'b1;
    assign tick   = run && (pre >= div_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || clr) begin
            pre <= '0;
        end else if (tick) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // R4: with a divider above one and unchanged, ticks never come back to back
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && div > DIV_W'(1)) |=> (!tick || div != $past(div)));

endmodule

// File: rtl/kswd_seq.sv
module kswd_seq
    import kswd_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic                         clr,
    input  logic                         tick,
    input  logic [STAGES-1:0][TMO_W-1:0] tmo,
    output logic                         expire,
    output logic [SIDX_W-1:0]            stage
);
    localparam logic [SIDX_W-1:0] LAST = SIDX_W'(STAGES - 1);

    logic [TMO_W-1:0] cnt;
    logic [TMO_W-1:0] cur;
    logic [TMO_W-1:0] lim_m1;
    logic             done;

    assign cur    = tmo[stage];
    assign lim_m1 = (cur == '0) ? '0 : cur - 1'b1;
    assign expire = run && !clr && tick && !done && (cnt >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || clr) begin
            cnt   <= '0;
            stage <= '0;
            done  <= 1'b0;
        end else if (expire) begin
            cnt <= '0;
            if (stage == LAST) done  <= 1'b1;
            else               stage <= stage + 1'b1;
        end else if (tick && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: an expiring non-final stage hands over to the next with a clear count
    assert_stage_step_R3: assert property (@(posedge clk) disable iff (rst)
        (expire && stage != LAST) |=> (stage == $past(stage) + 1'b1 && cnt == '0));

    // R5: a feed returns the sequence to stage 0 with nothing counted
    assert_feed_restart_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (stage == '0 && cnt == '0 && !done));

    // R10: after the final expiry the block stays put until fed or disabled
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (done && run && !clr) |=> (done && stage == LAST && !expire));

endmodule

// File: rtl/kswd_pulse.sv
module kswd_pulse
    import kswd_pkg::*;
#(
    parameter int UNIT   = 32,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              fire,
    input  logic [CODE_W-1:0] code,
    output logic              pulse
);
    localparam int MAXLEN = (2 ** CODE_W) * UNIT;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    logic [CNT_W-1:0] left;
    logic [CNT_W-1:0] load;

    assign load  = CNT_W'(pulse_cycles(int'(code), UNIT));
    assign pulse = (left != '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            left <= '0;
        end else if (fire) begin
            left <= load;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    // R7: a fired pulse is visible in the following cycle
    assert_fire_visible_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && run) |=> pulse);

endmodule

// File: rtl/kswd.sv
module kswd
    import kswd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DIV_W      = 16,
    parameter int TMO_W      = 32,
    parameter int PULSE_UNIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              cpu_rst_o,
    output logic              sys_rst_o
);
    ctrl_t                        ctrl;
    logic [DIV_W-1:0]             div;
    logic [STAGES-1:0][TMO_W-1:0] tmo;
    logic                         feed_p;
    logic                         iclr_p;
    logic                         tick;
    logic                         expire;
    logic [SIDX_W-1:0]            stage;
    logic [1:0]                   cur_act;
    logic                         irq_set;
    logic                         irq_q;

    logic [RST_KINDS-1:0]            rst_fire;
    logic [RST_KINDS-1:0][LEN_W-1:0] rst_code;
    logic [RST_KINDS-1:0]            rst_out;

    kswd_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .TMO_W(TMO_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .we     (bus_we),
        .ctrl   (ctrl),
        .div    (div),
        .tmo    (tmo),
        .feed_p (feed_p),
        .iclr_p (iclr_p),
        .rdata  (bus_rdata)
    );

    kswd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.enable),
        .clr  (feed_p),
        .div  (div),
        .tick (tick)
    );

    kswd_seq #(.TMO_W(TMO_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.enable),
        .clr    (feed_p),
        .tick   (tick),
        .tmo    (tmo),
        .expire (expire),
        .stage  (stage)
    );

    assign cur_act = ctrl.act[stage];
    assign irq_set = expire && (cur_act == ACT_IRQ);

    assign rst_fire[RST_CPU] = expire && (cur_act == ACT_CPU);
    assign rst_fire[RST_SYS] = expire && (cur_act == ACT_SYS);
    assign rst_code[RST_CPU] = ctrl.cpu_len;
    assign rst_code[RST_SYS] = ctrl.sys_len;

    for (genvar k = 0; k < RST_KINDS; k++) begin : g_rst
        kswd_pulse #(.UNIT(PULSE_UNIT), .CODE_W(LEN_W)) u_pulse (
            .clk   (clk),
            .rst   (rst),
            .run   (ctrl.enable),
            .fire  (rst_fire[k]),
            .code  (rst_code[k]),
            .pulse (rst_out[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.enable) begin
            irq_q <= 1'b0;
        end else if (irq_set) begin
            irq_q <= 1'b1;
        end else if (!ctrl.irq_level || iclr_p) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_o     = irq_q;
    assign cpu_rst_o = rst_out[RST_CPU];
    assign sys_rst_o = rst_out[RST_SYS];

    // R6: once enable is low, all outputs are quiet at the next cycle
    assert_disable_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> (!irq_o && !cpu_rst_o && !sys_rst_o));

    // R8: a level interrupt holds until cleared or disabled
    assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && ctrl.irq_level && irq_o && !iclr_p) |=> irq_o);

    // R8: in pulse mode the interrupt lasts one cycle only
    assert_pulse_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && !ctrl.irq_level && !irq_set) |=> !irq_o);

    // R11: a clear write drops the level interrupt
    assert_irq_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (iclr_p && !irq_set) |=> !irq_o);

    // R2: a CPU reset pulse only starts after a CPU-reset expiry
    assert_cpu_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst_o) |-> $past(rst_fire[RST_CPU]));

endmodule

// File: tb/test_kswd.sv
module test_kswd;
    localparam logic [31:0] KEY = 32'h50D8_3AA1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o, cpu_rst_o, sys_rst_o;

    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;

    kswd i_kswd (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int     m_unl, m_en, m_lvl, m_clen, m_slen, m_div, m_irq, m_stg, m_done;
    int     m_act[2];
    longint m_tmo[2];
    longint m_pre, m_cnt, m_cpu, m_sys;
    int     m_exp, m_a, m_feed, m_iclr;
    longint m_dm1, m_lim;

    always @(posedge clk) begin
        if (rst) begin
            m_unl = 0; m_en = 0; m_lvl = 0; m_clen = 0; m_slen = 0; m_div = 0;
            m_act[0] = 0; m_act[1] = 0; m_tmo[0] = 0; m_tmo[1] = 0;
            m_pre = 0; m_cnt = 0; m_stg = 0; m_done = 0;
            m_irq = 0; m_cpu = 0; m_sys = 0;
        end else begin
            m_feed = (bus_we && m_unl != 0 && bus_addr == 3'd4) ? 1 : 0;
            m_iclr = (bus_we && m_unl != 0 && bus_addr == 3'd6) ? 1 : 0;
            m_exp = 0; m_a = 0;
            if (m_en == 0 || m_feed != 0) begin
                m_pre = 0; m_cnt = 0; m_stg = 0; m_done = 0;
            end else begin
                m_dm1 = (m_div == 0) ? 0 : m_div - 1;
                if (m_pre >= m_dm1) begin
                    m_pre = 0;
                    if (m_done == 0) begin
                        m_lim = (m_tmo[m_stg] == 0) ? 1 : m_tmo[m_stg];
                        if (m_cnt + 1 >= m_lim) begin
                            m_exp = 1; m_a = m_act[m_stg]; m_cnt = 0;
                            if (m_stg == 1) m_done = 1; else m_stg = m_stg + 1;
                        end else begin
                            m_cnt = m_cnt + 1;
                        end
                    end
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            if (m_en == 0) m_irq = 0;
            else if (m_exp != 0 && m_a == 1) m_irq = 1;
            else if (m_lvl == 0 || m_iclr != 0) m_irq = 0;
            if (m_en == 0) m_cpu = 0;
            else if (m_exp != 0 && m_a == 2) m_cpu = (m_clen + 1) * 32;
            else if (m_cpu > 0) m_cpu = m_cpu - 1;
            if (m_en == 0) m_sys = 0;
            else if (m_exp != 0 && m_a == 3) m_sys = (m_slen + 1) * 32;
            else if (m_sys > 0) m_sys = m_sys - 1;
            if (bus_we) begin
                if (bus_addr == 3'd5) m_unl = (bus_wdata == KEY) ? 1 : 0;
                else if (m_unl != 0) begin
                    case (bus_addr)
                        3'd0: begin
                            m_en = bus_wdata[0]; m_lvl = bus_wdata[1];
                            m_act[0] = bus_wdata[3:2]; m_act[1] = bus_wdata[5:4];
                            m_clen = bus_wdata[8:6]; m_slen = bus_wdata[11:9];
                        end
                        3'd1: m_div = bus_wdata[15:0];
                        3'd2: m_tmo[0] = bus_wdata;
                        3'd3: m_tmo[1] = bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic longint model_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_en | (m_lvl << 1) | (m_act[0] << 2) | (m_act[1] << 4)
                         | (m_clen << 6) | (m_slen << 9);
            3'd1: return m_div;
            3'd2: return m_tmo[0];
            3'd3: return m_tmo[1];
            3'd5: return m_unl;
            default: return 0;
        endcase
    endfunction

    // per-cycle comparison against the model
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            chk(irq_o == (m_irq != 0), "R8", "model irq_o", irq_o, m_irq);
            chk(cpu_rst_o == (m_cpu > 0), "R7", "model cpu_rst_o", cpu_rst_o, m_cpu > 0);
            chk(sys_rst_o == (m_sys > 0), "R7", "model sys_rst_o", sys_rst_o, m_sys > 0);
            chk(longint'(bus_rdata) == model_rdata(bus_addr), "R1", "model bus_rdata",
                bus_rdata, model_rdata(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 3'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R0", "watchdog expired", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        longint t0, w, hits, hits2;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk(!irq_o && !cpu_rst_o && !sys_rst_o, "R6", "outputs after reset",
            {irq_o, cpu_rst_o, sys_rst_o}, 0);

        // R1: lock behaviour
        wr(3'd0, 32'h1);
        rd(3'd0, v); chk(v == 0, "R1", "locked ctrl write", v, 0);
        rd(3'd5, v); chk(v == 0, "R1", "key reads locked", v, 0);
        wr(3'd5, KEY);
        rd(3'd5, v); chk(v == 1, "R1", "key reads unlocked", v, 1);
        wr(3'd5, 32'h0);
        wr(3'd1, 32'd7);
        rd(3'd1, v); chk(v == 0, "R1", "divider write after relock", v, 0);
        wr(3'd5, KEY);

        // Scenario B: irq stage then CPU reset stage, level mode
        wr(3'd1, 32'd4); wr(3'd2, 32'd3); wr(3'd3, 32'd5);
        wr(3'd0, 32'h27);
        t0 = cyc;
        for (int i = 0; i < 500 && !irq_o; i++) @(negedge clk);
        chk(cyc - t0 == 12, "R3", "stage 0 expiry (ticks x divider)", cyc - t0, 12);
        chk(!cpu_rst_o, "R2", "no cpu reset at irq stage", cpu_rst_o, 0);
        for (int i = 0; i < 500 && !cpu_rst_o; i++) @(negedge clk);
        chk(cyc - t0 == 32, "R3", "stage 1 expiry", cyc - t0, 32);
        w = 0;
        for (int i = 0; i < 1000 && cpu_rst_o; i++) begin w++; @(negedge clk); end
        chk(w == 32, "R7", "cpu pulse width code 0", w, 32);
        chk(irq_o, "R8", "level irq held", irq_o, 1);
        hits = 0;
        for (int i = 0; i < 100; i++) begin
            if (cpu_rst_o || sys_rst_o) hits++;
            @(negedge clk);
        end
        chk(hits == 0, "R10", "no wrap after final stage", hits, 0);
        wr(3'd4, 32'h1);
        t0 = cyc;
        chk(irq_o, "R11", "feed leaves level irq", irq_o, 1);
        wr(3'd6, 32'h1);
        chk(!irq_o, "R11", "clear drops level irq", irq_o, 0);
        for (int i = 0; i < 500 && !irq_o; i++) @(negedge clk);
        chk(cyc - t0 == 12, "R5", "restart after feed", cyc - t0, 12);
        for (int i = 0; i < 500 && !cpu_rst_o; i++) @(negedge clk);
        chk(cyc - t0 == 32, "R5", "stage 1 after feed", cyc - t0, 32);

        // Scenario C: disable, then silent stage 0 and system reset stage
        wr(3'd0, 32'h0);
        @(negedge clk);
        chk(!irq_o && !cpu_rst_o && !sys_rst_o, "R6", "outputs after disable",
            {irq_o, cpu_rst_o, sys_rst_o}, 0);
        wr(3'd0, 32'h431);
        t0 = cyc;
        hits = 0; hits2 = 0;
        for (int i = 0; i < 500 && !sys_rst_o; i++) begin
            if (irq_o) hits++;
            if (cpu_rst_o) hits2++;
            @(negedge clk);
        end
        chk(cyc - t0 == 32, "R9", "silent stage still hands over", cyc - t0, 32);
        chk(hits == 0, "R9", "silent stage raises no irq", hits, 0);
        chk(hits2 == 0, "R2", "system action drives no cpu reset", hits2, 0);
        w = 0;
        for (int i = 0; i < 1000 && sys_rst_o; i++) begin w++; @(negedge clk); end
        chk(w == 96, "R7", "sys pulse width code 2", w, 96);

        // Scenario D: divider 0, timeout 0, pulse interrupt, disable mid-pulse
        wr(3'd0, 32'h0);
        wr(3'd1, 32'd0); wr(3'd2, 32'd2); wr(3'd3, 32'd0);
        wr(3'd0, 32'h1E5);
        t0 = cyc;
        for (int i = 0; i < 100 && !irq_o; i++) @(negedge clk);
        chk(cyc - t0 == 2, "R4", "divider 0 acts as 1", cyc - t0, 2);
        @(negedge clk);
        chk(!irq_o, "R8", "pulse irq lasts one cycle", irq_o, 0);
        for (int i = 0; i < 100 && !cpu_rst_o; i++) @(negedge clk);
        chk(cyc - t0 == 3, "R3", "timeout 0 acts as 1", cyc - t0, 3);
        repeat (10) @(negedge clk);
        wr(3'd0, 32'h0);
        @(negedge clk);
        chk(!cpu_rst_o, "R6", "disable cuts pulse short", cpu_rst_o, 0);
        hits = 0;
        for (int i = 0; i < 50; i++) begin
            if (irq_o || cpu_rst_o || sys_rst_o) hits++;
            @(negedge clk);
        end
        chk(hits == 0, "R6", "no activity while disabled", hits, 0);

        // Scenario E: relock while running, feed must be ignored
        wr(3'd1, 32'd2); wr(3'd2, 32'd20); wr(3'd3, 32'd1000);
        wr(3'd0, 32'h05);
        t0 = cyc;
        wr(3'd5, 32'h1234);
        wr(3'd4, 32'h1);
        for (int i = 0; i < 200 && !irq_o; i++) @(negedge clk);
        chk(cyc - t0 == 40, "R1", "locked feed ignored", cyc - t0, 40);
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk(v == 32'h05, "R1", "locked disable ignored", v, 5);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule